// File: doc/BRIEF.md
# ALU Instruction Sequencer with Shared Buses

This block is a small datapath plus the control that steps it. Every transfer goes over a shared bus: an address bus (default 16 bits) and a data bus (default 8 bits). It holds a program counter, a separate incrementer register, an instruction register, two destination registers (A and D), two operand registers (B and C) and a three-bit flag register.

Each instruction takes four single-cycle steps, and the sequence then starts again:

1. The instruction byte is fetched from an external byte-wide read port.
2. The program counter plus one is captured into the incrementer register.
3. That value is copied back into the program counter over the address bus.
4. The ALU instruction executes.

In every step the sequencer raises drive strobes, which choose the one source on each bus, and capture strobes, which choose the registers that take the bus value.

The surrounding logic supplies instruction bytes through `mem_rdata`, with the data valid in the same cycle as the address. It preloads the operand registers through `set_bc`. It reads results from the A and D registers and from the flags.

Top module: `alu_seq_ctrl`

## Requirements
- R1: After reset the step is fetch (0), and the program counter, instruction register, A, B, C, D and all three flags are zero.
- R2: Steps advance one per clock in the order fetch (0), increment (1), commit (2), execute (3), and from execute return to fetch.
- R3: In fetch, the address bus carries the program counter and `mem_rd` is 1. The instruction register captures `mem_rdata` at the end of that cycle and holds it in all other steps.
- R4: The program counter is unchanged through fetch and increment. It takes its old value plus one at the end of the commit step.
- R5: The program counter wraps from its all-ones value to zero.
- R6: An opcode of the form 1000_rfff is an ALU instruction. r=0 writes A and r=1 writes D, in the execute step. The results for each value of fff are:
  - 000: B+C
  - 001: B+1
  - 010: B AND C
  - 011: B OR C
  - 100: B XOR C
  - 101: NOT B
  - 110: B rotated left by one
  - 111: no write
- R7: Flags are loaded only in an executing ALU instruction with fff not equal to 111. Carry is the carry-out of functions 000 and 001 and 0 for all others. Zero is 1 when the result is 0. Sign is bit 7 of the result.
- R8: Any opcode whose upper nibble is not 1000 leaves A, D and the flags unchanged, and still advances the program counter by one.
- R9: At most one source drives each bus in any step. The address bus carries the program counter in increment and the incrementer register in commit, and `mem_rd` is 0 outside fetch.
- R10: While `set_bc` is 1, B and C take `b_in` and `c_in` at the clock edge, and the following ALU instruction operates on those values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_bc | input | 1 | Operand preload enable |
| b_in | input | DW | Value for operand register B |
| c_in | input | DW | Value for operand register C |
| mem_rdata | input | DW | Instruction byte at the current address |
| mem_rd | output | 1 | Memory read strobe (fetch step) |
| addr_bus | output | AW | Shared address bus |
| data_bus | output | DW | Shared data bus |
| step_o | output | 2 | Current step code |
| pc_o | output | AW | Program counter |
| ir_o | output | DW | Instruction register |
| reg_a_o | output | DW | Destination register A |
| reg_d_o | output | DW | Destination register D |
| flag_c_o | output | 1 | Carry flag |
| flag_z_o | output | 1 | Zero flag |
| flag_s_o | output | 1 | Sign flag |

## Verification
The bench builds the block with a 10-bit address bus and keeps the 8-bit data width. With that address width, running plain no-operation instructions from the start carries the program counter to its all-ones value and across the wrap in about four thousand cycles. The 8-bit data width keeps the ALU carry, zero and sign corners and the rotate wrap of bit 7 reachable through a short vector table.

// File: rtl/aseq_pkg.sv
package aseq_pkg;

  typedef enum logic [1:0] {
    ST_FETCH  = 2'd0,
    ST_BUMP   = 2'd1,
    ST_COMMIT = 2'd2,
    ST_EXEC   = 2'd3
  } step_e;

  // function field of an ALU-class opcode; the order is decoded from the opcode
  typedef enum logic [2:0] {
    FN_ADD  = 3'd0,
    FN_INC  = 3'd1,
    FN_AND  = 3'd2,
    FN_OR   = 3'd3,
    FN_XOR  = 3'd4,
    FN_NOT  = 3'd5,
    FN_ROL  = 3'd6,
    FN_IDLE = 3'd7
  } alu_fn_e;

  // who places a value on a bus this step
  typedef struct packed {
    logic pc_to_abus;
    logic inc_to_abus;
    logic mem_to_dbus;
    logic alu_to_dbus;
  } drive_t;

  // who captures a bus value at the end of this step
  typedef struct packed {
    logic ir_ld;
    logic inc_ld;
    logic pc_ld;
    logic dst_ld;
    logic flag_ld;
  } capture_t;

  typedef struct packed {
    logic carry;
    logic zero;
    logic sign;
  } flags_t;

  localparam logic [3:0] ALU_CLASS = 4'b1000;

endpackage

// File: rtl/aseq_sequencer.sv
module aseq_sequencer
  import aseq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     is_alu,
  input  alu_fn_e  alu_fn,
  output step_e    step,
  output drive_t   drive,
  output capture_t capture,
  output logic     mem_rd
);

  step_e step_q;
  logic  exec_writes;

  always_ff @(posedge clk) begin
    if (!rst_n) step_q <= ST_FETCH;
    else        step_q <= step_e'(step_q + 2'd1);
  end

  assign step        = step_q;
  assign exec_writes = is_alu && (alu_fn != FN_IDLE);

  always_comb begin
    drive   = '0;
    capture = '0;
    mem_rd  = 1'b0;
    unique case (step_q)
      ST_FETCH: begin
        drive.pc_to_abus  = 1'b1;
        drive.mem_to_dbus = 1'b1;
        capture.ir_ld     = 1'b1;
        mem_rd            = 1'b1;
      end
      ST_BUMP: begin
        drive.pc_to_abus = 1'b1;
        capture.inc_ld   = 1'b1;
      end
      ST_COMMIT: begin
        drive.inc_to_abus = 1'b1;
        capture.pc_ld     = 1'b1;
      end
      ST_EXEC: begin
        drive.alu_to_dbus = exec_writes;
        capture.dst_ld    = exec_writes;
        capture.flag_ld   = exec_writes;
      end
      default: ;
    endcase
  end

  assert_step_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == ST_EXEC) |=> (step_q == ST_FETCH));

endmodule

// File: rtl/aseq_addr_path.sv
module aseq_addr_path
  import aseq_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  step_e         step,
  input  drive_t        drive,
  input  capture_t      capture,
  output logic [AW-1:0] addr_bus,
  output logic [AW-1:0] pc
);

  logic [AW-1:0] pc_q;
  logic [AW-1:0] inc_q;
  logic [AW-1:0] bumped;

  function automatic logic [AW-1:0] next_addr(input logic [AW-1:0] v);
    return v + {{(AW-1){1'b0}}, 1'b1};
  endfunction

  always_comb begin
    addr_bus = '0;
    if (drive.pc_to_abus)       addr_bus = pc_q;
    else if (drive.inc_to_abus) addr_bus = inc_q;
  end

  assign bumped = next_addr(addr_bus);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= '0;
      inc_q <= '0;
    end else begin
      if (capture.inc_ld) inc_q <= bumped;
      if (capture.pc_ld)  pc_q  <= addr_bus;
    end
  end

  assign pc = pc_q;

  assert_one_addr_driver_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({drive.pc_to_abus, drive.inc_to_abus}));

  assert_pc_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step != ST_COMMIT) |=> $stable(pc_q));

  assert_pc_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_COMMIT && $past(step) == ST_BUMP) |=> (pc_q == AW'($past(pc_q) + 1'b1)));

endmodule

// File: rtl/aseq_alu.sv
module aseq_alu
  import aseq_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_fn_e       fn,
  input  logic [DW-1:0] b,
  input  logic [DW-1:0] c,
  output logic [DW-1:0] result,
  output flags_t        flags
);

  // carry in the top bit, result below
  function automatic logic [DW:0] compute(input alu_fn_e f, input logic [DW-1:0] x,
                                          input logic [DW-1:0] y);
    logic [DW:0] r;
    unique case (f)
      FN_ADD:  r = {1'b0, x} + {1'b0, y};
      FN_INC:  r = {1'b0, x} + {{DW{1'b0}}, 1'b1};
      FN_AND:  r = {1'b0, x & y};
      FN_OR:   r = {1'b0, x | y};
      FN_XOR:  r = {1'b0, x ^ y};
      FN_NOT:  r = {1'b0, ~x};
      FN_ROL:  r = {1'b0, x[DW-2:0], x[DW-1]};
      default: r = '0;
    endcase
    return r;
  endfunction

  logic [DW:0] raw;

  assign raw         = compute(fn, b, c);
  assign result      = raw[DW-1:0];
  assign flags.carry = raw[DW];
  assign flags.zero  = (raw[DW-1:0] == '0);
  assign flags.sign  = raw[DW-1];

endmodule

// File: rtl/aseq_data_path.sv
module aseq_data_path
  import aseq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  step_e         step,
  input  drive_t        drive,
  input  capture_t      capture,
  input  logic [DW-1:0] mem_rdata,
  input  logic          set_bc,
  input  logic [DW-1:0] b_in,
  input  logic [DW-1:0] c_in,
  output logic [DW-1:0] data_bus,
  output logic [DW-1:0] ir,
  output logic [DW-1:0] reg_a,
  output logic [DW-1:0] reg_d,
  output flags_t        flags,
  output logic          is_alu,
  output alu_fn_e       alu_fn
);

  localparam int CLS_HI = DW - 1;
  localparam int DST_BIT = 3;

  logic [DW-1:0] ir_q, a_q, b_q, c_q, d_q;
  flags_t        flg_q;
  logic [DW-1:0] alu_res;
  flags_t        alu_flg;
  logic          dst_is_d;

  assign is_alu   = (ir_q[CLS_HI -: 4] == ALU_CLASS);
  assign alu_fn   = alu_fn_e'(ir_q[2:0]);
  assign dst_is_d = ir_q[DST_BIT];

  aseq_alu #(.DW(DW)) u_alu (
    .fn     (alu_fn),
    .b      (b_q),
    .c      (c_q),
    .result (alu_res),
    .flags  (alu_flg)
  );

  always_comb begin
    data_bus = '0;
    if (drive.mem_to_dbus)      data_bus = mem_rdata;
    else if (drive.alu_to_dbus) data_bus = alu_res;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ir_q  <= '0;
      a_q   <= '0;
      b_q   <= '0;
      c_q   <= '0;
      d_q   <= '0;
      flg_q <= '0;
    end else begin
      if (capture.ir_ld) ir_q <= data_bus;
      if (capture.dst_ld) begin
        if (dst_is_d) d_q <= data_bus;
        else          a_q <= data_bus;
      end
      if (capture.flag_ld) flg_q <= alu_flg;
      if (set_bc) begin
        b_q <= b_in;
        c_q <= c_in;
      end
    end
  end

  assign ir    = ir_q;
  assign reg_a = a_q;
  assign reg_d = d_q;
  assign flags = flg_q;

  assert_one_data_driver_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({drive.mem_to_dbus, drive.alu_to_dbus}));

  assert_ir_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step != ST_FETCH) |=> $stable(ir_q));

  assert_flags_only_exec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step != ST_EXEC) |=> $stable(flg_q));

  assert_nonalu_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_EXEC && !is_alu) |=> ($stable(a_q) && $stable(d_q) && $stable(flg_q)));

endmodule

// File: rtl/alu_seq_ctrl.sv
module alu_seq_ctrl
  import aseq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_bc,
  input  logic [DW-1:0] b_in,
  input  logic [DW-1:0] c_in,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_rd,
  output logic [AW-1:0] addr_bus,
  output logic [DW-1:0] data_bus,
  output logic [1:0]    step_o,
  output logic [AW-1:0] pc_o,
  output logic [DW-1:0] ir_o,
  output logic [DW-1:0] reg_a_o,
  output logic [DW-1:0] reg_d_o,
  output logic          flag_c_o,
  output logic          flag_z_o,
  output logic          flag_s_o
);

  step_e    step;
  drive_t   drive;
  capture_t capture;
  logic     is_alu;
  alu_fn_e  alu_fn;
  flags_t   flags;

  aseq_sequencer u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .is_alu  (is_alu),
    .alu_fn  (alu_fn),
    .step    (step),
    .drive   (drive),
    .capture (capture),
    .mem_rd  (mem_rd)
  );

  aseq_addr_path #(.AW(AW)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step),
    .drive    (drive),
    .capture  (capture),
    .addr_bus (addr_bus),
    .pc       (pc_o)
  );

  aseq_data_path #(.DW(DW)) u_data (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step),
    .drive     (drive),
    .capture   (capture),
    .mem_rdata (mem_rdata),
    .set_bc    (set_bc),
    .b_in      (b_in),
    .c_in      (c_in),
    .data_bus  (data_bus),
    .ir        (ir_o),
    .reg_a     (reg_a_o),
    .reg_d     (reg_d_o),
    .flags     (flags),
    .is_alu    (is_alu),
    .alu_fn    (alu_fn)
  );

  assign step_o   = step;
  assign flag_c_o = flags.carry;
  assign flag_z_o = flags.zero;
  assign flag_s_o = flags.sign;

endmodule

// File: tb/alu_seq_ctrl_bench.sv
`timescale 1ns/1ps
module alu_seq_ctrl_bench;

  localparam int BAW = 10;
  localparam int BDW = 8;
  localparam int MEMSZ = 1 << BAW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic set_bc = 1'b0;
  logic [BDW-1:0] b_in = '0, c_in = '0;
  logic [BDW-1:0] mem_rdata;
  logic mem_rd;
  logic [BAW-1:0] addr_bus, pc_o;
  logic [BDW-1:0] data_bus, ir_o, reg_a_o, reg_d_o;
  logic [1:0] step_o;
  logic flag_c_o, flag_z_o, flag_s_o;

  logic [7:0] mem [MEMSZ];

  always #2 clk = ~clk;
  assign mem_rdata = mem[addr_bus];

  alu_seq_ctrl #(.AW(BAW), .DW(BDW)) u_alu_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .set_bc(set_bc), .b_in(b_in), .c_in(c_in),
    .mem_rdata(mem_rdata), .mem_rd(mem_rd), .addr_bus(addr_bus), .data_bus(data_bus),
    .step_o(step_o), .pc_o(pc_o), .ir_o(ir_o), .reg_a_o(reg_a_o), .reg_d_o(reg_d_o),
    .flag_c_o(flag_c_o), .flag_z_o(flag_z_o), .flag_s_o(flag_s_o)
  );

  int checks = 0;
  int errors = 0;

  int exp_pc;
  int exp_a, exp_d;
  logic [2:0] exp_f;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model in integer arithmetic: updates exp_a/exp_d/exp_f
  task automatic model(input logic [7:0] op, input int b, input int c);
    int r;
    int cy;
    int fn;
    if (op[7:4] != 4'b1000) return;
    fn = op[2:0];
    cy = 0;
    case (fn)
      0: begin r = b + c; cy = (r > 255) ? 1 : 0; r = r % 256; end
      1: begin r = b + 1; cy = (r > 255) ? 1 : 0; r = r % 256; end
      2: r = b & c;
      3: r = b | c;
      4: r = b ^ c;
      5: r = 255 - b;
      6: r = ((b * 2) % 256) + (b / 128);
      default: return;
    endcase
    if (op[3]) exp_d = r; else exp_a = r;
    exp_f = {cy[0], (r == 0), (r >= 128)};
  endtask

  task automatic run_instr(input logic [7:0] op, input int b, input int c);
    int old_pc;
    old_pc = exp_pc;
    check("R2 step at fetch", step_o, 0);
    check("R3 fetch addr", addr_bus, old_pc);
    check("R3 mem_rd in fetch", mem_rd, 1);
    mem[old_pc] = op;
    set_bc = 1'b1; b_in = b[7:0]; c_in = c[7:0];
    @(posedge clk); @(negedge clk);
    set_bc = 1'b0;
    check("R2 step increment", step_o, 1);
    check("R3 ir captured", ir_o, op);
    check("R9 addr in increment", addr_bus, old_pc);
    check("R9 mem_rd off", mem_rd, 0);
    @(posedge clk); @(negedge clk);
    check("R2 step commit", step_o, 2);
    check("R4 pc held", pc_o, old_pc);
    check("R9 inc on addr bus", addr_bus, (old_pc + 1) % MEMSZ);
    @(posedge clk); @(negedge clk);
    check("R2 step execute", step_o, 3);
    exp_pc = (old_pc + 1) % MEMSZ;
    check("R4 pc advanced", pc_o, exp_pc);
    model(op, b, c);
    @(posedge clk); @(negedge clk);
    check("R6 reg A", reg_a_o, exp_a);
    check("R6 reg D", reg_d_o, exp_d);
    check("R7 flags", {flag_c_o, flag_z_o, flag_s_o}, exp_f);
  endtask

  task automatic check_reset_state(input string tag);
    check({"R1 step ", tag}, step_o, 0);
    check({"R1 pc ", tag}, pc_o, 0);
    check({"R1 ir ", tag}, ir_o, 0);
    check({"R1 A ", tag}, reg_a_o, 0);
    check({"R1 D ", tag}, reg_d_o, 0);
    check({"R1 flags ", tag}, {flag_c_o, flag_z_o, flag_s_o}, 0);
  endtask

  // opcode, B, C
  localparam logic [23:0] VEC [12] = '{
    {8'h80, 8'h7F, 8'h01},  // add -> 0x80, sign
    {8'h88, 8'hFF, 8'h01},  // add into D -> 0x00, carry+zero
    {8'h81, 8'hFF, 8'h00},  // inc wraps -> carry
    {8'h89, 8'h41, 8'h00},  // inc into D
    {8'h82, 8'hF0, 8'h3C},  // and
    {8'h8B, 8'h0F, 8'hA0},  // or into D
    {8'h84, 8'h5A, 8'h5A},  // xor equal -> zero
    {8'h85, 8'h0F, 8'h00},  // not
    {8'h8E, 8'h81, 8'h00},  // rotate: bit 7 wraps into bit 0
    {8'h87, 8'h12, 8'h34},  // idle code: no write
    {8'h92, 8'h01, 8'h01},  // outside ALU class
    {8'hC0, 8'hFF, 8'hFF}   // outside ALU class
  };

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < MEMSZ; i++) mem[i] = 8'h00;
    exp_pc = 0; exp_a = 0; exp_d = 0; exp_f = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check_reset_state("after reset");

    // table walk: R6 R7 R8 R10
    for (int v = 0; v < 12; v++) begin
      run_instr(VEC[v][23:16], int'(VEC[v][15:8]), int'(VEC[v][7:0]));
    end

    // R8: non-ALU after ALU keeps A, D, flags; A and D nonzero here
    check("R8 A nonzero before", (reg_a_o != 0) ? 1 : 0, 1);
    run_instr(8'h3F, 8'h00, 8'h00);
    check("R8 A kept", reg_a_o, exp_a);

    // R10: B and C ignored while set_bc is low
    run_instr(8'h80, 8'h10, 8'h20);
    @(posedge clk); @(negedge clk);
    b_in = 8'hEE; c_in = 8'hEE;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    exp_pc = (exp_pc + 1) % MEMSZ;
    check("R10 A unchanged after replay", reg_a_o, 8'h30);
    // the previous byte at this pc is 0x00 (non-ALU) so just realign model
    run_instr(8'h80, 8'h10, 8'h20);
    check("R10 A from loaded B C", reg_a_o, 8'h30);

    // R5: run to the top of the address space and across it
    while (exp_pc != MEMSZ - 1) run_instr(8'h00, 0, 0);
    run_instr(8'h00, 0, 0);
    check("R5 pc wrapped", pc_o, 0);
    check("R5 fetch at zero", addr_bus, 0);

    // R1: reset in the middle of an instruction
    run_instr(8'h85, 8'h00, 8'h00);
    @(posedge clk); @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    rst_n = 1'b1;
    exp_pc = 0; exp_a = 0; exp_d = 0; exp_f = '0;
    check_reset_state("mid-run");
    run_instr(8'h8D, 8'hFF, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule